// File: doc/BRIEF.md
# Dead-Zone Uniform Coefficient Quantizer

This block sits directly at the output of a wavelet transform and turns each signed fixed-point coefficient into a sign-magnitude quantization index as it streams past. A separate divide-based quantization pass is then not needed. The step size is always a power of two. It is chosen by the decomposition-level tag that travels with the coefficient. Each deeper level keeps one more bit of precision, so its step is half the step of the level above.

Two reduction modes are selected per coefficient. Truncation floors the magnitude, which gives a zero bin twice as wide as every other bin. Round-to-nearest rounds the magnitude, with ties going away from zero. The datapath is fully pipelined with a fixed latency of two cycles. The valid flag, the subband tag and the level tag move through the pipeline beside the data, so downstream logic receives them aligned with the index.

Top module: `dzq_quantizer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0.
- R2: `out_valid`, `out_band` and `out_level` reproduce `in_valid`, `in_band` and `in_level` exactly two clock cycles later. An input cycle with `in_valid` low yields an output cycle with `out_valid` low.
- R3: In truncation mode (`in_round` = 0), `out_mag` = floor(|x| / 2^s), where x is the two's complement value of `in_coef` and s is the step shift for the level.
- R4: In truncation mode, every x with |x| < 2^s gives `out_mag` = 0. The zero bin therefore spans 2·2^s, while every other bin spans 2^s.
- R5: The step shift is s = BASE_SHIFT − `in_level`. Level code 0 is the first decomposition level. A level tag beyond LEVELS−1 uses the shift of level LEVELS−1.
- R6: In round mode (`in_round` = 1), `out_mag` = floor((|x| + 2^(s−1)) / 2^s). A magnitude exactly halfway between two indices goes to the larger magnitude.
- R7: `out_sign` is 1 exactly when x < 0 and `out_mag` ≠ 0. A zero index is never negative.
- R8: The most negative input −2^(COEF_W−1) gives `out_sign` = 1 and `out_mag` = 2^(COEF_W−1−s), with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input coefficient is valid |
| in_coef | input | COEF_W | Signed two's complement coefficient |
| in_round | input | 1 | 0 = truncate, 1 = round to nearest (ties away from zero) |
| in_band | input | 2 | Subband tag, passed through |
| in_level | input | $clog2(LEVELS) | Decomposition level code, 0 = first level |
| out_valid | output | 1 | Output index is valid |
| out_sign | output | 1 | Sign of the index, 1 = negative |
| out_mag | output | COEF_W | Index magnitude |
| out_band | output | 2 | Subband tag aligned with the index |
| out_level | output | $clog2(LEVELS) | Level tag aligned with the index |

## Verification
The bench sweeps every coefficient value of a 10-bit configuration through every level and both modes. This reaches the bin edges on both sides of zero, the exact halfway points and the most negative code. If the rounding took place before the magnitude was formed, negative values just below a bin edge would land one index off, and the zero bin would become lopsided. An off-by-one in the level-to-shift mapping shows up as every index at one level being doubled or halved. A design that negated the most negative code in too few bits would report a magnitude of zero or a wrong sign there. A design that passed the sign through unconditionally would emit a negative zero for small negative inputs. Idle cycles inserted into the stream catch valid or tag misalignment in the pipeline.

// File: rtl/dzq_pkg.sv
package dzq_pkg;

  typedef enum logic { MODE_TRUNC = 1'b0, MODE_ROUND = 1'b1 } reduce_mode_e;

  // Step shift for a level code: each deeper level keeps one more bit.
  function automatic int unsigned step_shift(int unsigned base, int unsigned lvl);
    return base - lvl;
  endfunction

  // Level code clamped to the deepest configured level.
  function automatic int unsigned clamp_level(int unsigned lvl, int unsigned levels);
    return (lvl < levels) ? lvl : levels - 1;
  endfunction

endpackage

// File: rtl/dzq_mag_stage.sv
module dzq_mag_stage #(
  parameter int COEF_W     = 16,
  parameter int LEVELS     = 4,
  parameter int BASE_SHIFT = 6,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int SH_W      = $clog2(BASE_SHIFT + 1),
  localparam int TAB_N     = 2 ** LVL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [COEF_W-1:0] in_coef,
  input  logic                     in_round,
  input  logic [1:0]               in_band,
  input  logic [LVL_W-1:0]         in_level,
  output logic                     s1_valid,
  output logic                     s1_neg,
  output logic [COEF_W-1:0]        s1_mag,
  output logic [SH_W-1:0]          s1_shift,
  output logic                     s1_round,
  output logic [1:0]               s1_band,
  output logic [LVL_W-1:0]         s1_level
);
  import dzq_pkg::*;

  // Shift per level code, filled at elaboration; unused codes take the deepest level.
  logic [SH_W-1:0] shift_tab [TAB_N];
  for (genvar g = 0; g < TAB_N; g++) begin : g_shift_tab
    assign shift_tab[g] = SH_W'(step_shift(BASE_SHIFT, clamp_level(g, LEVELS)));
  end

  // Magnitude in COEF_W unsigned bits: the most negative code maps to 2^(COEF_W-1).
  logic [COEF_W-1:0] mag_c;
  always_comb begin
    mag_c = in_coef[COEF_W-1] ? (~in_coef + 1'b1) : in_coef;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_neg   <= 1'b0;
      s1_mag   <= '0;
      s1_shift <= '0;
      s1_round <= 1'b0;
      s1_band  <= '0;
      s1_level <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_neg   <= in_coef[COEF_W-1];
      s1_mag   <= mag_c;
      s1_shift <= shift_tab[in_level];
      s1_round <= in_round;
      s1_band  <= in_band;
      s1_level <= in_level;
    end
  end

endmodule

// File: rtl/dzq_reduce_stage.sv
module dzq_reduce_stage #(
  parameter int COEF_W     = 16,
  parameter int LEVELS     = 4,
  parameter int BASE_SHIFT = 6,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int SH_W      = $clog2(BASE_SHIFT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic               s1_neg,
  input  logic [COEF_W-1:0]  s1_mag,
  input  logic [SH_W-1:0]    s1_shift,
  input  logic               s1_round,
  input  logic [1:0]         s1_band,
  input  logic [LVL_W-1:0]   s1_level,
  output logic               out_valid,
  output logic               out_sign,
  output logic [COEF_W-1:0]  out_mag,
  output logic [1:0]         out_band,
  output logic [LVL_W-1:0]   out_level
);
  import dzq_pkg::*;

  // Half-step bias is added to the magnitude only when rounding, so ties move away from zero.
  logic [COEF_W:0]   bias;
  logic [COEF_W:0]   biased;
  logic [COEF_W-1:0] idx;
  logic              idx_zero;

  always_comb begin
    bias = '0;
    if (reduce_mode_e'(s1_round) == MODE_ROUND && s1_shift != '0) begin
      bias = (COEF_W+1)'(1) << (s1_shift - 1'b1);
    end
    biased   = {1'b0, s1_mag} + bias;
    idx      = COEF_W'(biased >> s1_shift);
    idx_zero = (idx == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_mag   <= '0;
      out_band  <= '0;
      out_level <= '0;
    end else begin
      out_valid <= s1_valid;
      out_sign  <= s1_neg & ~idx_zero;
      out_mag   <= idx;
      out_band  <= s1_band;
      out_level <= s1_level;
    end
  end

endmodule

// File: rtl/dzq_quantizer.sv
module dzq_quantizer #(
  parameter int COEF_W     = 16,
  parameter int LEVELS     = 4,   // at least 2; BASE_SHIFT must be at least LEVELS-1
  parameter int BASE_SHIFT = 6,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int SH_W      = $clog2(BASE_SHIFT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [COEF_W-1:0] in_coef,
  input  logic                     in_round,
  input  logic [1:0]               in_band,
  input  logic [LVL_W-1:0]         in_level,
  output logic                     out_valid,
  output logic                     out_sign,
  output logic [COEF_W-1:0]        out_mag,
  output logic [1:0]               out_band,
  output logic [LVL_W-1:0]         out_level
);

  logic              s1_valid;
  logic              s1_neg;
  logic [COEF_W-1:0] s1_mag;
  logic [SH_W-1:0]   s1_shift;
  logic              s1_round;
  logic [1:0]        s1_band;
  logic [LVL_W-1:0]  s1_level;

  dzq_mag_stage #(
    .COEF_W(COEF_W), .LEVELS(LEVELS), .BASE_SHIFT(BASE_SHIFT)
  ) u_mag (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_coef(in_coef), .in_round(in_round),
    .in_band(in_band), .in_level(in_level),
    .s1_valid(s1_valid), .s1_neg(s1_neg), .s1_mag(s1_mag), .s1_shift(s1_shift),
    .s1_round(s1_round), .s1_band(s1_band), .s1_level(s1_level)
  );

  dzq_reduce_stage #(
    .COEF_W(COEF_W), .LEVELS(LEVELS), .BASE_SHIFT(BASE_SHIFT)
  ) u_reduce (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_neg(s1_neg), .s1_mag(s1_mag), .s1_shift(s1_shift),
    .s1_round(s1_round), .s1_band(s1_band), .s1_level(s1_level),
    .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag),
    .out_band(out_band), .out_level(out_level)
  );

endmodule

// File: rtl/dzq_quantizer_chk.sv
module dzq_quantizer_chk #(
  parameter int COEF_W     = 16,
  parameter int LEVELS     = 4,
  parameter int BASE_SHIFT = 6,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int RW        = COEF_W + BASE_SHIFT + 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic signed [COEF_W-1:0] in_coef,
  input logic                     in_round,
  input logic [1:0]               in_band,
  input logic [LVL_W-1:0]         in_level,
  input logic                     out_valid,
  input logic                     out_sign,
  input logic [COEF_W-1:0]        out_mag,
  input logic [1:0]               out_band,
  input logic [LVL_W-1:0]         out_level
);

  // Inputs delayed by two cycles to line up with the outputs.
  logic                     d1_valid, d2_valid, d1_round, d2_round;
  logic signed [COEF_W-1:0] d1_coef, d2_coef;
  logic [1:0]               d1_band, d2_band;
  logic [LVL_W-1:0]         d1_level, d2_level;
  logic [1:0]               live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1_valid <= 1'b0; d2_valid <= 1'b0; d1_round <= 1'b0; d2_round <= 1'b0;
      d1_coef  <= '0;   d2_coef  <= '0;   d1_band  <= '0;   d2_band  <= '0;
      d1_level <= '0;   d2_level <= '0;   live     <= '0;
    end else begin
      d1_valid <= in_valid; d2_valid <= d1_valid;
      d1_round <= in_round; d2_round <= d1_round;
      d1_coef  <= in_coef;  d2_coef  <= d1_coef;
      d1_band  <= in_band;  d2_band  <= d1_band;
      d1_level <= in_level; d2_level <= d1_level;
      if (live != 2'd2) live <= live + 2'd1;
    end
  end

  logic          primed;
  int            sh;
  logic [RW-1:0] absx, recon, stp, half;

  always_comb begin
    primed = (live == 2'd2);
    sh     = BASE_SHIFT - ((int'(d2_level) < LEVELS) ? int'(d2_level) : LEVELS - 1);
    absx   = d2_coef[COEF_W-1] ? RW'(-int'(d2_coef)) : RW'(d2_coef);
    stp    = RW'(1) << sh;
    half   = stp >> 1;
    recon  = RW'(out_mag) << sh;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !out_valid);

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (out_valid == d2_valid));

  // R2
  tag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid) |-> (out_band == d2_band && out_level == d2_level));

  // R3
  trunc_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && !d2_round) |-> (recon <= absx && absx < recon + stp));

  // R4
  dead_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && !d2_round && absx < stp) |-> (out_mag == '0));

  // R6
  round_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && d2_round) |-> (recon <= absx + half && absx + half < recon + stp));

  // R7
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mag == '0) |-> !out_sign);

  // R7
  sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && out_mag != '0) |-> (out_sign == d2_coef[COEF_W-1]));

endmodule

bind dzq_quantizer dzq_quantizer_chk #(
  .COEF_W(COEF_W), .LEVELS(LEVELS), .BASE_SHIFT(BASE_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
  .in_round(in_round), .in_band(in_band), .in_level(in_level),
  .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag),
  .out_band(out_band), .out_level(out_level)
);

// File: tb/dzq_quantizer_bench.sv
`timescale 1ns/1ps
module dzq_quantizer_bench;
  localparam int CW = 10;
  localparam int LV = 4;
  localparam int BS = 4;
  localparam int LW = $clog2(LV);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [CW-1:0] in_coef = '0;
  logic                 in_round = 1'b0;
  logic [1:0]           in_band = '0;
  logic [LW-1:0]        in_level = '0;
  logic                 out_valid, out_sign;
  logic [CW-1:0]        out_mag;
  logic [1:0]           out_band;
  logic [LW-1:0]        out_level;

  always #2 clk = ~clk;

  dzq_quantizer #(.COEF_W(CW), .LEVELS(LV), .BASE_SHIFT(BS)) u_dzq_quantizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
    .in_round(in_round), .in_band(in_band), .in_level(in_level),
    .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag),
    .out_band(out_band), .out_level(out_level)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Two-deep queue of expected outputs.
  logic  e1_v = 0, e2_v = 0, e1_s = 0, e2_s = 0;
  int    e1_m = 0, e2_m = 0, e1_b = 0, e2_b = 0, e1_l = 0, e2_l = 0;
  string e1_t = "R2", e2_t = "R2";

  task automatic check_out();
    checks++;
    if (out_valid !== e2_v) begin
      errors++;
      $display("FAIL R2 valid: got %0b expected %0b", out_valid, e2_v);
    end else if (e2_v) begin
      checks++;
      if (out_sign !== e2_s || int'(out_mag) != e2_m) begin
        errors++;
        $display("FAIL %s index: got sign=%0b mag=%0d expected sign=%0b mag=%0d",
                 e2_t, out_sign, out_mag, e2_s, e2_m);
      end
      checks++;
      if (int'(out_band) != e2_b || int'(out_level) != e2_l) begin
        errors++;
        $display("FAIL R2 tags: got band=%0d level=%0d expected band=%0d level=%0d",
                 out_band, out_level, e2_b, e2_l);
      end
    end
  endtask

  // One cycle: check the output due now, then present a new input.
  task automatic step(input logic v, input int x, input logic rnd, input int band,
                      input int lvl, input string force_tag);
    int a, sh, d, m;
    string t;
    @(negedge clk);
    check_out();
    a  = (x < 0) ? -x : x;
    sh = BS - lvl;               // R5
    d  = 1;
    for (int k = 0; k < sh; k++) d = d * 2;
    m  = rnd ? (a + d / 2) / d : a / d;
    if (force_tag != "")              t = force_tag;
    else if (x == -(1 << (CW - 1)))   t = "R8";
    else if (x < 0 && m == 0)         t = "R7";
    else if (!rnd && a < d)           t = "R4";
    else if (rnd)                     t = "R6";
    else                              t = "R3";
    e2_v = e1_v; e2_s = e1_s; e2_m = e1_m; e2_b = e1_b; e2_l = e1_l; e2_t = e1_t;
    e1_v = v; e1_s = (x < 0) && (m != 0); e1_m = m; e1_b = band; e1_l = lvl; e1_t = t;
    in_valid = v;
    in_coef  = CW'(x);
    in_round = rnd;
    in_band  = 2'(band);
    in_level = LW'(lvl);
  endtask

  initial begin
    int n;
    // R1: quiet during reset
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: got out_valid=%0b expected 0", out_valid);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after release
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 release: got out_valid=%0b expected 0", out_valid);
    end

    // R5: one value across all levels, each level halves the step
    for (int l = 0; l < LV; l++) step(1'b1, 100, 1'b0, 1, l, "R5");
    for (int l = 0; l < LV; l++) step(1'b1, -77, 1'b1, 2, l, "R5");

    // Exhaustive sweep: both modes, all levels, every coefficient, with idle gaps (R2)
    n = 0;
    for (int r = 0; r < 2; r++) begin
      for (int l = 0; l < LV; l++) begin
        for (int v = 0; v < (1 << CW); v++) begin
          n++;
          if (n % 13 == 0) step(1'b0, 5, 1'b0, 0, 0, "R2");
          step(1'b1, v - (1 << (CW - 1)), r[0], (v + l) % 4, l, "");
        end
      end
    end

    // R8: most negative code at the finest and coarsest steps
    step(1'b1, -(1 << (CW - 1)), 1'b0, 3, LV - 1, "R8");
    step(1'b1, -(1 << (CW - 1)), 1'b1, 3, 0, "R8");
    // R6: exact ties on both sides of zero at level 0 (step 16)
    step(1'b1, 24, 1'b1, 0, 0, "R6");
    step(1'b1, -24, 1'b1, 0, 0, "R6");
    step(1'b1, -8, 1'b1, 0, 0, "R6");
    // R4: just inside and at the zero-bin edge in truncation
    step(1'b1, -15, 1'b0, 1, 0, "R4");
    step(1'b1, 16, 1'b0, 1, 0, "R4");
    // drain the pipeline
    step(1'b0, 0, 1'b0, 0, 0, "R2");
    step(1'b0, 0, 1'b0, 0, 0, "R2");
    @(negedge clk);
    check_out();
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          errors++;
          checks++;
          $display("FAIL watchdog: got no completion expected completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule